// File: doc/BRIEF.md
# Three-State Phase Comparator with Lock Flag

This block compares two pulse streams inside a frequency synthesizer loop. One stream comes from the divided reference, and the other comes from the divided oscillator. Each stream arrives as a one-clock strobe, synchronous to the system clock. The block reports which stream's edge came first, using two active-low error flags. It also folds the same information into a single-ended error output, described as a drive-enable plus a level. Finally, it raises a lock flag whenever neither stream is ahead.

When one edge arrives first, that side's flag drops, and it stays low until the other edge appears. Both flags then sit low together for a fixed minimum width. After that they release together. A loop that is in frequency and phase agreement therefore shows only the brief coincident pulse on both flags. During that pulse the single-ended output stays undriven and the lock flag stays high.

Top module: `tri_state_phase_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are as follows: `err_vco_n`=1, `err_ref_n`=1, `se_oe`=0, `se_level`=0 and `lock`=0. This holds whatever the pulse inputs do.
- R2: A `vco_pulse` sampled with no comparison in progress drives `err_vco_n` low from the next cycle onward, and `err_ref_n` stays high. This continues until a `ref_pulse` is sampled.
- R3: A `ref_pulse` sampled with no comparison in progress drives `err_ref_n` low from the next cycle onward, and `err_vco_n` stays high. This continues until a `vco_pulse` is sampled.
- R4: When the second edge is sampled, both flags are low for exactly MIN_W cycles (default 2). After that, both flags return high.
- R5: A `ref_pulse` and a `vco_pulse` sampled in the same cycle with no comparison in progress produce only the MIN_W-cycle coincident pulse. No single-flag phase appears.
- R6: `se_oe` is 1 exactly in cycles where one flag alone is low. In those cycles `se_level` is 0 if `err_vco_n` is the low flag and 1 if `err_ref_n` is the low flag. Otherwise `se_oe`=0 and `se_level`=0, which is the high-impedance state.
- R7: Outside reset, `lock` is 0 in every cycle where exactly one flag is low, and 1 in all other cycles.
- R8: Further strobes from the leading stream, arriving while its flag is already low, have no effect. The pulse still ends only on the other stream's edge.
- R9: Strobes sampled while both flags are low are discarded. After the coincident pulse the block returns to idle, with both flags high and `lock`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle strobe per divided reference edge |
| vco_pulse | input | 1 | One-cycle strobe per divided oscillator edge |
| err_vco_n | output | 1 | Low while the oscillator side leads, and during the coincident pulse |
| err_ref_n | output | 1 | Low while the reference side leads, and during the coincident pulse |
| se_oe | output | 1 | Single-ended error drive enable |
| se_level | output | 1 | Single-ended error level when driven |
| lock | output | 1 | High when neither stream leads |

## Verification
The bench sweeps both arrival orders over gaps from zero to five cycles. It compares every cycle against expected output vectors, so a design that ends the lead pulse one cycle early or late, or that stretches or shortens the coincident pulse, is caught on the first mismatching cycle. Same-cycle arrivals must show no lead phase; a design that gives one input priority instead would show a one-sided pulse and a driven single-ended output. Duplicate leading strobes and strobes injected during the coincident window are applied: a design that restarts the comparison on them would show a spurious extra pulse or a dropped lock flag. A reset taken in the middle of a lead phase must return the block to the reset state.

// File: rtl/phcmp_pkg.sv
// Shared types for the three-state phase comparator.
package phcmp_pkg;

    // Comparison phase: idle, one side ahead, or both flags low together.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_VLEAD = 2'd1,
        PH_RLEAD = 2'd2,
        PH_COIN  = 2'd3
    } ph_state_t;

endpackage

// File: rtl/phcmp_arbiter.sv
// Decides which strobe arrived first and times the coincident pulse.
// Assumes strobes are one clock wide and synchronous to clk.
// Strobes seen during the coincident window are discarded.
module phcmp_arbiter
    import phcmp_pkg::*;
#(
    parameter int MIN_W = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_pulse,
    input  logic      vco_pulse,
    output ph_state_t state,
    output ph_state_t state_nxt
);

    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

    logic [CW-1:0] coin_cnt;

    // Next-phase selection from the current phase and sampled strobes.
    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_IDLE: begin
                if (ref_pulse && vco_pulse) state_nxt = PH_COIN;
                else if (vco_pulse)         state_nxt = PH_VLEAD;
                else if (ref_pulse)         state_nxt = PH_RLEAD;
            end
            PH_VLEAD: if (ref_pulse) state_nxt = PH_COIN;
            PH_RLEAD: if (vco_pulse) state_nxt = PH_COIN;
            PH_COIN:  if (coin_cnt == LAST) state_nxt = PH_IDLE;
            default:  state_nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nxt;
    end

    // Counts cycles spent in the coincident phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                 coin_cnt <= '0;
        else if (state == PH_COIN)  coin_cnt <= coin_cnt + 1'b1;
        else                        coin_cnt <= '0;
    end

endmodule

// File: rtl/phcmp_drive.sv
// Maps the comparison phase onto the double-ended flags and the
// single-ended error output (drive enable plus level).
// Purely combinational; assumes a registered phase input.
module phcmp_drive
    import phcmp_pkg::*;
(
    input  ph_state_t state,
    output logic      err_vco_n,
    output logic      err_ref_n,
    output logic      se_oe,
    output logic      se_level
);

    // Flag and single-ended decode.
    always_comb begin
        err_vco_n = !(state == PH_VLEAD || state == PH_COIN);
        err_ref_n = !(state == PH_RLEAD || state == PH_COIN);
        se_oe     = (state == PH_VLEAD) || (state == PH_RLEAD);
        se_level  = (state == PH_RLEAD);
    end

endmodule

// File: rtl/phcmp_lock.sv
// Lock flag: low while one side leads, high otherwise, low in reset.
// Registered from the next phase, so it aligns with the flags.
module phcmp_lock
    import phcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ph_state_t state_nxt,
    output logic      lock
);

    // Lock register update.
    always_ff @(posedge clk) begin
        if (!rst_n) lock <= 1'b0;
        else        lock <= !(state_nxt == PH_VLEAD || state_nxt == PH_RLEAD);
    end

endmodule

// File: rtl/tri_state_phase_detector.sv
// Top of the three-state phase comparator.
// It compares reference and oscillator edge strobes and reports the
// lead, lag or coincidence through two active-low flags, a
// single-ended error output and a lock flag.
// Assumes one-clock strobes synchronous to clk.
module tri_state_phase_detector
    import phcmp_pkg::*;
#(
    parameter int MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic vco_pulse,
    output logic err_vco_n,
    output logic err_ref_n,
    output logic se_oe,
    output logic se_level,
    output logic lock
);

    ph_state_t state;
    ph_state_t state_nxt;

    phcmp_arbiter #(.MIN_W(MIN_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .vco_pulse (vco_pulse),
        .state     (state),
        .state_nxt (state_nxt)
    );

    phcmp_drive drv_i (
        .state     (state),
        .err_vco_n (err_vco_n),
        .err_ref_n (err_ref_n),
        .se_oe     (se_oe),
        .se_level  (se_level)
    );

    phcmp_lock lck_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .lock      (lock)
    );

endmodule

// File: rtl/tri_state_phase_detector_chk.sv
// Property checker for the phase comparator, bound to the top module.
// Watches ports only, plus a run counter for the coincident pulse.
module tri_state_phase_detector_chk #(
    parameter int MIN_W = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ref_pulse,
    input logic vco_pulse,
    input logic err_vco_n,
    input logic err_ref_n,
    input logic se_oe,
    input logic se_level,
    input logic lock
);

    logic both_low;
    int   run;

    assign both_low = !err_vco_n && !err_ref_n;

    // Length of the current coincident run, in prior cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= 0;
        else if (both_low) run <= run + 1;
        else               run <= 0;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (err_vco_n && err_ref_n && !se_oe && !se_level && !lock)); // R1

    AST_COIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        both_low |-> (run < MIN_W)); // R4

    AST_COIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!both_low && run != 0) |-> (run == MIN_W)); // R4

    AST_SIMUL_COIN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vco_n && err_ref_n && ref_pulse && vco_pulse) |=> (both_low && !se_oe)); // R5

    AST_SE_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        se_oe |-> ((err_vco_n ^ err_ref_n) && (se_level == !err_ref_n))); // R6

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vco_n ^ err_ref_n) |-> !lock); // R7

    AST_LEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vco_n && err_ref_n && !ref_pulse) |=> (!err_vco_n && err_ref_n)); // R8

endmodule

bind tri_state_phase_detector tri_state_phase_detector_chk #(.MIN_W(MIN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .vco_pulse (vco_pulse),
    .err_vco_n (err_vco_n),
    .err_ref_n (err_ref_n),
    .se_oe     (se_oe),
    .se_level  (se_level),
    .lock      (lock)
);

// File: tb/tri_state_phase_detector_tb_top.sv
// Sweep bench: both arrival orders, gaps 0..5, with and without
// redundant strobes, plus reset checks.
module tri_state_phase_detector_tb_top;

    localparam int MIN_W = 2;
    // Expected vector layout: {err_vco_n, err_ref_n, se_oe, se_level, lock}
    localparam logic [4:0] EXP_RST  = 5'b11000;
    localparam logic [4:0] EXP_IDLE = 5'b11001;
    localparam logic [4:0] EXP_VL   = 5'b01100;
    localparam logic [4:0] EXP_RL   = 5'b10110;
    localparam logic [4:0] EXP_CO   = 5'b00001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic vco_pulse = 1'b0;
    logic err_vco_n, err_ref_n, se_oe, se_level, lock;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = !clk;

    tri_state_phase_detector #(.MIN_W(MIN_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .vco_pulse (vco_pulse),
        .err_vco_n (err_vco_n),
        .err_ref_n (err_ref_n),
        .se_oe     (se_oe),
        .se_level  (se_level),
        .lock      (lock)
    );

    task automatic check(input logic [4:0] exp, input string tag);
        logic [4:0] got;
        got = {err_vco_n, err_ref_n, se_oe, se_level, lock};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Present strobes for one edge, then return to the falling edge.
    task automatic step(input logic r, input logic v);
        ref_pulse = r;
        vco_pulse = v;
        @(posedge clk);
        @(negedge clk);
        ref_pulse = 1'b0;
        vco_pulse = 1'b0;
    endtask

    task automatic run_case(input bit vfirst, input int gap, input bit dup);
        if (gap == 0) step(1'b1, 1'b1);
        else          step(!vfirst, vfirst);
        for (int i = 1; i <= gap; i++) begin
            if (vfirst) check(EXP_VL, "R2 R6 R7 R8 vco lead");
            else        check(EXP_RL, "R3 R6 R7 R8 ref lead");
            if (i == gap) step(vfirst || dup, !vfirst || dup);
            else          step(dup && !vfirst, dup && vfirst);
        end
        for (int j = 1; j <= MIN_W; j++) begin
            if (gap == 0) check(EXP_CO, "R5 R4 simultaneous");
            else          check(EXP_CO, "R4 R6 R7 coincident");
            step(dup, dup);
        end
        check(EXP_IDLE, "R4 R9 idle after pulse");
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        check(EXP_RST, "R1 reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check(EXP_IDLE, "R7 idle after reset");
        for (int d = 0; d < 2; d++)
            for (int o = 0; o < 2; o++)
                for (int g = 0; g <= 5; g++)
                    run_case(o[0], g, d[0]);
        step(1'b0, 1'b1);
        check(EXP_VL, "R2 lead before reset");
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        check(EXP_RST, "R1 reset mid lead");
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check(EXP_IDLE, "R1 release");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule